// File: doc/BRIEF.md
# Multi-Mode PWM Timer with Buffered Compares

This block is a 16-bit timer-counter with four compare channels. A 3-bit mode field picks one of several counting schemes: plain up-counting, frequency generation, single-slope PWM, or one of three dual-slope PWM schemes. The mode sets how the counter moves, what its TOP value is, when compare values are refreshed, when the overflow flag fires, and which waveform each channel produces. The counter advances only on cycles where the prescaled tick input is high.

Each channel has two registers: a buffer that writes land in, and an active compare register. The buffer is copied into the active register on the mode's UPDATE event. A lock bit can hold off that copy. Software can set and clear the lock bit directly. Auto-lock can instead manage it, releasing the copy only once every enabled channel has received a fresh buffer write.

Each pin carries the general-purpose port value by default. A channel's waveform replaces the port value on its pin only when that channel's enable bit is set and the mode produces a waveform. An external override input takes priority over both.

Top module: `pwm_timer`

## Requirements
- R1: Modes 0 (normal), 2 and 4 (reserved) count up from 0 to the period value `per_i` and then wrap to 0. These modes produce no waveform, so each pin shows its port value unless the external override is active.
- R2: Mode 3 (single-slope) counts 0..`per_i` and wraps. The channel output is set on the wrapping tick and cleared on a tick taken while the count equals the channel's compare value.
- R3: Modes 5, 6 and 7 (dual-slope) count up to `per_i` and then down to 0, changing direction on the tick taken at each end. `count_down_o` is 1 while counting down. The output is cleared by a compare-match tick while counting up and set by one while counting down.
- R4: Mode 1 (frequency) uses compare channel 0 as TOP: the counter wraps to 0 on the tick taken at a count equal to that compare value. Each channel's output toggles on its own compare-match tick.
- R5: `ovf_o` pulses for one cycle after a tick taken at TOP (modes 0 to 5) or at BOTTOM while counting down (modes 6 and 7). Mode 6 pulses at both ends; mode 7 pulses at BOTTOM only.
- R6: `cmp_flag_o[n]` pulses for one cycle after any tick taken while the count equals compare value n.
- R7: A pulse on `buf_wr_i[n]` loads `buf_data_i` into buffer n and sets `buf_valid_o[n]`. The UPDATE event is the TOP tick in modes 0 to 4 and the BOTTOM tick in modes 5 to 7. At UPDATE with the lock clear, every valid buffer is copied to its compare register (channel n is `cmp_o[16n+15:16n]`) and its valid flag clears.
- R8: While `lock_o` is 1, UPDATE events leave the compare registers and the valid flags unchanged.
- R9: A rising edge of `auto_lock_i` sets the lock. While auto-lock is on, the lock clears one cycle after every channel enabled in `cmp_en_i` has its valid flag set. The lock is set again by the UPDATE event that performs the copy.
- R10: With `auto_lock_i` low, a pulse on `lock_wr_i` writes `lock_wdata_i` into the lock. With `auto_lock_i` high, such writes have no effect.
- R11: Pin n is chosen in this priority order: `ext_ovr_val_i[n]` when `ext_ovr_en_i[n]` is set; otherwise the channel waveform when `cmp_en_i[n]` is set and the mode is 1, 3, 5, 6 or 7; otherwise `port_val_i[n]`.
- R12: After reset, the count, direction, lock, valid flags, compare registers, waveforms and flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable |
| mode_i | input | 3 | Waveform/counting mode |
| per_i | input | 16 | Period (TOP) value |
| cmp_en_i | input | 4 | Per-channel pin enable |
| auto_lock_i | input | 1 | Auto-lock enable |
| lock_wr_i | input | 1 | Manual lock write strobe |
| lock_wdata_i | input | 1 | Manual lock write value |
| buf_wr_i | input | 4 | Per-channel buffer write strobe |
| buf_data_i | input | 16 | Buffer write data |
| port_val_i | input | 4 | General-purpose port output values |
| ext_ovr_en_i | input | 4 | External override enable per pin |
| ext_ovr_val_i | input | 4 | External override value per pin |
| pin_o | output | 4 | Pin values |
| ovf_o | output | 1 | Overflow pulse |
| cmp_flag_o | output | 4 | Compare-match pulses |
| cnt_o | output | 16 | Counter value |
| count_down_o | output | 1 | Counting direction (1 = down) |
| lock_o | output | 1 | Lock-update state |
| buf_valid_o | output | 4 | Buffer-valid flags |
| cmp_o | output | 64 | Active compare registers, channel n at bits 16n+15:16n |

## Verification
The counter, direction, waveforms, flags, valid bits, compare registers and lock are all registered. Each therefore changes at the clock edge that samples the tick or write, and the bench reads them at the falling edge that follows. The pins are combinational from the waveform registers and the inputs, so they are valid at that same falling edge, and immediately after a change to an override or enable input. Overflow and compare flags last one cycle, so they are sampled at the falling edge right after the tick, before the idle cycle that the tick task inserts. Auto-lock release needs the valid flags to be registered first. It is therefore checked one further falling edge after the last buffer write.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [2:0] {
    MODE_NORMAL  = 3'd0,
    MODE_FREQ    = 3'd1,
    MODE_RSV2    = 3'd2,
    MODE_SSPWM   = 3'd3,
    MODE_RSV4    = 3'd4,
    MODE_DS_TOP  = 3'd5,
    MODE_DS_BOTH = 3'd6,
    MODE_DS_BOT  = 3'd7
  } wg_mode_e;

  function automatic logic is_dual(input wg_mode_e m);
    return (m == MODE_DS_TOP) || (m == MODE_DS_BOTH) || (m == MODE_DS_BOT);
  endfunction

  function automatic logic is_wave(input wg_mode_e m);
    return (m == MODE_FREQ) || (m == MODE_SSPWM) || is_dual(m);
  endfunction
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  wg_mode_e         mode_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             down_o,
  output logic             top_evt_o,
  output logic             bot_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             down_q;
  logic             dual, at_top, at_bot, top_zero;

  assign dual     = is_dual(mode_i);
  assign top_zero = (top_i == '0);
  assign at_top   = (cnt_q >= top_i) && !(dual && down_q);
  assign at_bot   = dual && down_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (tick_i) begin
      if (dual) begin
        if (!down_q) begin
          if (at_top) begin
            down_q <= 1'b1;
            cnt_q  <= top_zero ? '0 : top_i - 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (cnt_q == '0) begin
          down_q <= 1'b0;
          cnt_q  <= top_zero ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        down_q <= 1'b0;
        cnt_q  <= at_top ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign down_o    = down_q;
  assign top_evt_o = tick_i && at_top;
  assign bot_evt_o = tick_i && at_bot;

  // R3: direction turns up after the bottom tick
  a_r3_turn_at_bottom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && dual && down_q && cnt_q == '0) |=> !down_q);
  // R1: single-direction modes wrap to zero at TOP
  a_r1_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !dual && cnt_q >= top_i) |=> (cnt_q == '0));
  // idle cycles hold the count
  a_r1_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        upd_i,
  input  logic [N_CH-1:0]             buf_wr_i,
  input  logic [CNT_W-1:0]            buf_data_i,
  input  logic [N_CH-1:0]             cmp_en_i,
  input  logic                        auto_lock_i,
  input  logic                        lock_wr_i,
  input  logic                        lock_wdata_i,
  output logic [N_CH-1:0][CNT_W-1:0]  cmp_o,
  output logic [N_CH-1:0]             valid_o,
  output logic                        lock_o
);
  logic [N_CH-1:0][CNT_W-1:0] buf_q, cmp_q;
  logic [N_CH-1:0]            bv_q;
  logic                       lock_q, auto_prev_q;
  logic                       do_xfer, all_valid;

  assign do_xfer   = upd_i && !lock_q;
  assign all_valid = ((bv_q & cmp_en_i) == cmp_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      cmp_q <= '0;
      bv_q  <= '0;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        if (do_xfer && bv_q[i]) cmp_q[i] <= buf_q[i];
        if (buf_wr_i[i]) begin
          buf_q[i] <= buf_data_i;
          bv_q[i]  <= 1'b1;
        end else if (do_xfer) begin
          bv_q[i]  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q      <= 1'b0;
      auto_prev_q <= 1'b0;
    end else begin
      auto_prev_q <= auto_lock_i;
      if (auto_lock_i) begin
        if (!auto_prev_q)              lock_q <= 1'b1;
        else if (lock_q && all_valid)  lock_q <= 1'b0;
        else if (do_xfer)              lock_q <= 1'b1;
      end else if (lock_wr_i) begin
        lock_q <= lock_wdata_i;
      end
    end
  end

  assign cmp_o   = cmp_q;
  assign valid_o = bv_q;
  assign lock_o  = lock_q;

  a_r8_hold_when_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && lock_q) |=> $stable(cmp_q));
  a_r7_write_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|buf_wr_i) |=> ((bv_q & $past(buf_wr_i)) == $past(buf_wr_i)));
  a_r9_relock_on_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_lock_i && $past(auto_lock_i) && upd_i && !lock_q) |=> lock_q);
  a_r10_lock_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_lock_i && !lock_wr_i) |=> $stable(lock_q));
endmodule

// File: rtl/pwm_wave_ch.sv
module pwm_wave_ch
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  wg_mode_e         mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             top_evt_i,
  output logic             wave_o,
  output logic             match_o
);
  logic wave_q;

  assign match_o = tick_i && (cnt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
    end else begin
      unique case (mode_i)
        MODE_FREQ:  if (match_o) wave_q <= ~wave_q;
        MODE_SSPWM: begin
          if (top_evt_i)    wave_q <= 1'b1;
          else if (match_o) wave_q <= 1'b0;
        end
        MODE_DS_TOP, MODE_DS_BOTH, MODE_DS_BOT:
                    if (match_o) wave_q <= down_i;
        default:    wave_q <= wave_q;
      endcase
    end
  end

  assign wave_o = wave_q;

  a_r1_no_wave_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {MODE_NORMAL, MODE_RSV2, MODE_RSV4}) |=> $stable(wave_q));
  a_r4_toggle_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FREQ && match_o) |=> (wave_q != $past(wave_q)));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [2:0]            mode_i,
  input  logic [CNT_W-1:0]      per_i,
  input  logic [N_CH-1:0]       cmp_en_i,
  input  logic                  auto_lock_i,
  input  logic                  lock_wr_i,
  input  logic                  lock_wdata_i,
  input  logic [N_CH-1:0]       buf_wr_i,
  input  logic [CNT_W-1:0]      buf_data_i,
  input  logic [N_CH-1:0]       port_val_i,
  input  logic [N_CH-1:0]       ext_ovr_en_i,
  input  logic [N_CH-1:0]       ext_ovr_val_i,
  output logic [N_CH-1:0]       pin_o,
  output logic                  ovf_o,
  output logic [N_CH-1:0]       cmp_flag_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  count_down_o,
  output logic                  lock_o,
  output logic [N_CH-1:0]       buf_valid_o,
  output logic [N_CH*CNT_W-1:0] cmp_o
);
  wg_mode_e                   mode;
  logic [CNT_W-1:0]           top_val, cnt;
  logic                       down, top_evt, bot_evt, upd, ovf_d, ovf_q, wave_en;
  logic [N_CH-1:0][CNT_W-1:0] cmp_arr;
  logic [N_CH-1:0]            wave, match, flag_q;

  assign mode    = wg_mode_e'(mode_i);
  assign top_val = (mode == MODE_FREQ) ? cmp_arr[0] : per_i;
  assign upd     = is_dual(mode) ? bot_evt : top_evt;
  assign wave_en = is_wave(mode);

  always_comb begin
    unique case (mode)
      MODE_DS_BOTH: ovf_d = top_evt || bot_evt;
      MODE_DS_BOT:  ovf_d = bot_evt;
      default:      ovf_d = top_evt;
    endcase
  end

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .mode_i(mode), .top_i(top_val),
    .cnt_o(cnt), .down_o(down), .top_evt_o(top_evt), .bot_evt_o(bot_evt)
  );

  pwm_cmp_bank #(.CNT_W(CNT_W), .N_CH(N_CH)) u_bank (
    .clk_i, .rst_ni, .upd_i(upd), .buf_wr_i, .buf_data_i, .cmp_en_i,
    .auto_lock_i, .lock_wr_i, .lock_wdata_i,
    .cmp_o(cmp_arr), .valid_o(buf_valid_o), .lock_o
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm_wave_ch #(.CNT_W(CNT_W)) u_wave (
      .clk_i, .rst_ni, .tick_i, .mode_i(mode), .cnt_i(cnt), .down_i(down),
      .cmp_i(cmp_arr[g]), .top_evt_i(top_evt),
      .wave_o(wave[g]), .match_o(match[g])
    );
    // priority: external override, then enabled waveform, then port value
    assign pin_o[g] = ext_ovr_en_i[g] ? ext_ovr_val_i[g]
                    : (wave_en && cmp_en_i[g]) ? wave[g] : port_val_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      flag_q <= '0;
    end else begin
      ovf_q  <= ovf_d;
      flag_q <= match;
    end
  end

  assign ovf_o        = ovf_q;
  assign cmp_flag_o   = flag_q;
  assign cnt_o        = cnt;
  assign count_down_o = down;
  assign cmp_o        = cmp_arr;

  a_r5_ovf_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !ovf_q);
  a_r6_flag_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (flag_q == '0));
endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;
  localparam int CNT_W = 16;
  localparam int N_CH  = 4;
  localparam int NV    = 14;

  // mode, period, compare0, ticks -> count, direction, pin0
  localparam int V_MODE [NV] = '{3,3,3, 5,5,5, 1,1,1, 0,2,4, 7,6};
  localparam int V_PER  [NV] = '{4,4,4, 4,4,4, 9,9,9, 5,5,3, 3,3};
  localparam int V_CMP  [NV] = '{2,2,2, 2,2,2, 3,3,3, 2,2,1, 1,1};
  localparam int V_TCK  [NV] = '{5,7,8, 6,7,9, 4,6,8, 4,7,3, 6,3};
  localparam int V_CNT  [NV] = '{0,2,3, 2,1,1, 0,2,0, 4,1,3, 0,3};
  localparam int V_DIR  [NV] = '{0,0,0, 1,1,0, 0,0,0, 0,0,0, 1,0};
  localparam int V_PIN  [NV] = '{1,1,0, 0,1,1, 1,1,0, 1,1,1, 1,0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic [CNT_W-1:0] per_i = '0;
  logic [N_CH-1:0] cmp_en_i = '0;
  logic auto_lock_i = 1'b0, lock_wr_i = 1'b0, lock_wdata_i = 1'b0;
  logic [N_CH-1:0] buf_wr_i = '0;
  logic [CNT_W-1:0] buf_data_i = '0;
  logic [N_CH-1:0] port_val_i = '0, ext_ovr_en_i = '0, ext_ovr_val_i = '0;
  logic [N_CH-1:0] pin_o, cmp_flag_o, buf_valid_o;
  logic ovf_o, count_down_o, lock_o;
  logic [CNT_W-1:0] cnt_o;
  logic [N_CH*CNT_W-1:0] cmp_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_timer #(.CNT_W(CNT_W), .N_CH(N_CH)) dut (
    .clk_i(clk), .rst_ni, .tick_i, .mode_i, .per_i, .cmp_en_i, .auto_lock_i,
    .lock_wr_i, .lock_wdata_i, .buf_wr_i, .buf_data_i, .port_val_i,
    .ext_ovr_en_i, .ext_ovr_val_i, .pin_o, .ovf_o, .cmp_flag_o, .cnt_o,
    .count_down_o, .lock_o, .buf_valid_o, .cmp_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    tick_i = 0; mode_i = 0; per_i = 0; cmp_en_i = 0; auto_lock_i = 0;
    lock_wr_i = 0; lock_wdata_i = 0; buf_wr_i = 0; buf_data_i = 0;
    port_val_i = 0; ext_ovr_en_i = 0; ext_ovr_val_i = 0;
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic tick_once();
    @(negedge clk) tick_i = 1;
    @(negedge clk) tick_i = 0;
  endtask

  task automatic write_buf(input int ch, input int val);
    @(negedge clk);
    buf_wr_i[ch] = 1'b1;
    buf_data_i   = CNT_W'(val);
    @(negedge clk);
    buf_wr_i = '0;
  endtask

  task automatic lock_write(input bit v);
    @(negedge clk);
    lock_wr_i = 1; lock_wdata_i = v;
    @(negedge clk);
    lock_wr_i = 0;
  endtask

  function automatic int cmp_of(input int ch);
    return int'(cmp_o[ch*CNT_W +: CNT_W]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    do_reset();
    port_val_i = 4'b0110;
    #1;
    chk("R12 cnt", int'(cnt_o), 0);
    chk("R12 dir", int'(count_down_o), 0);
    chk("R12 lock", int'(lock_o), 0);
    chk("R12 valid", int'(buf_valid_o), 0);
    chk("R12 cmp", (cmp_o == '0) ? 1 : 0, 1);
    chk("R12 ovf", int'(ovf_o), 0);
    chk("R12 flags", int'(cmp_flag_o), 0);
    chk("R12 pins", int'(pin_o), 4'b0110);

    // Vector table: R1 R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      do_reset();
      port_val_i = 4'b1111;
      cmp_en_i   = 4'b0001;
      per_i      = 1;
      write_buf(0, V_CMP[v]);
      tick_once(); tick_once();   // wrap in normal mode loads compare 0
      chk("R7 prime", cmp_of(0), V_CMP[v]);
      mode_i = 3'(V_MODE[v]);
      per_i  = CNT_W'(V_PER[v]);
      for (int t = 0; t < V_TCK[v]; t++) tick_once();
      chk($sformatf("R1/R2/R3/R4 v%0d cnt", v), int'(cnt_o), V_CNT[v]);
      chk($sformatf("R3 v%0d dir", v), int'(count_down_o), V_DIR[v]);
      chk($sformatf("R11 v%0d pin", v), int'(pin_o[0]), V_PIN[v]);
    end

    // R5: overflow placement across the dual-slope variants, per=3
    for (int m = 5; m <= 7; m++) begin
      int total;
      int at_top;
      total = 0; at_top = 0;
      do_reset();
      mode_i = 3'(m);
      per_i  = 3;
      for (int t = 0; t < 7; t++) begin
        tick_once();
        if (ovf_o) begin
          total++;
          if (t == 3) at_top = 1;
        end
      end
      chk($sformatf("R5 mode%0d top pulse", m), at_top, (m == 7) ? 0 : 1);
      chk($sformatf("R5 mode%0d pulses", m), total, (m == 6) ? 2 : 1);
    end
    // R5: single-slope overflow at wrap, then clears
    do_reset();
    mode_i = 3; per_i = 2;
    tick_once(); tick_once();
    chk("R5 ss before top", int'(ovf_o), 0);
    tick_once();
    chk("R5 ss at top", int'(ovf_o), 1);
    @(negedge clk);
    chk("R5 pulse width", int'(ovf_o), 0);

    // R6: compare flag pulse
    do_reset();
    per_i = 1;
    write_buf(0, 2);
    tick_once(); tick_once();
    per_i = 5;
    tick_once(); tick_once();
    chk("R6 no match yet", int'(cmp_flag_o[0]), 0);
    tick_once();
    chk("R6 match flag", int'(cmp_flag_o[0]), 1);
    tick_once();
    chk("R6 flag clears", int'(cmp_flag_o[0]), 0);

    // R9 R10 R8 R7: auto-lock
    do_reset();
    per_i = 1; cmp_en_i = 4'b0011;
    @(negedge clk) auto_lock_i = 1;
    @(negedge clk);
    chk("R9 rise sets lock", int'(lock_o), 1);
    lock_write(1'b0);
    chk("R10 write ignored in auto", int'(lock_o), 1);
    write_buf(0, 7);
    tick_once(); tick_once();
    chk("R8 cmp0 held", cmp_of(0), 0);
    chk("R8 valid kept", int'(buf_valid_o), 4'b0001);
    chk("R9 lock stays partial", int'(lock_o), 1);
    write_buf(1, 9);
    chk("R7 valid both", int'(buf_valid_o), 4'b0011);
    chk("R9 lock before release", int'(lock_o), 1);
    @(negedge clk);
    chk("R9 release", int'(lock_o), 0);
    tick_once(); tick_once();
    chk("R7 cmp0 xfer", cmp_of(0), 7);
    chk("R7 cmp1 xfer", cmp_of(1), 9);
    chk("R7 valid cleared", int'(buf_valid_o), 0);
    chk("R9 relock", int'(lock_o), 1);

    // R10 R8 R7: manual lock
    do_reset();
    per_i = 1;
    lock_write(1'b1);
    chk("R10 manual set", int'(lock_o), 1);
    write_buf(2, 5);
    tick_once(); tick_once();
    chk("R8 manual hold", cmp_of(2), 0);
    chk("R8 valid held", int'(buf_valid_o), 4'b0100);
    lock_write(1'b0);
    chk("R10 manual clear", int'(lock_o), 0);
    tick_once(); tick_once();
    chk("R7 cmp2 xfer", cmp_of(2), 5);
    chk("R7 valid clear", int'(buf_valid_o), 0);

    // R11: pin priority
    do_reset();
    port_val_i = 4'b1010;
    mode_i = 3; per_i = 4;
    #1;
    chk("R11 disabled -> port", int'(pin_o), 4'b1010);
    cmp_en_i = 4'b1111; #1;
    chk("R11 enabled -> wave", int'(pin_o), 4'b0000);
    ext_ovr_en_i = 4'b0011; ext_ovr_val_i = 4'b0001; #1;
    chk("R11 ext override", int'(pin_o), 4'b0001);
    ext_ovr_en_i = 0; mode_i = 0; #1;
    chk("R1 normal -> port", int'(pin_o), 4'b1010);
    mode_i = 4; #1;
    chk("R1 reserved -> port", int'(pin_o), 4'b1010);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule